// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor

This block gives the fetch stage a guess for each program counter it presents: whether the instruction there redirects flow and, if so, where to. It combines three structures. A two-way set-associative target cache holds the destinations of branches that have been taken. A table of 2-bit saturating direction counters is indexed by the PC mixed with a global outcome history. A short return-address stack serves subroutine returns. The lookup is combinational, so fetch reads `pred_taken` and `pred_target` in the same cycle that it drives `fetch_pc`.

Execute reports each resolved branch on the update port. A resolved branch moves its direction counter one step and shifts its outcome into the history register. If it was taken, it also writes its target into the target cache, using one LRU bit per set to pick the victim. Fetch flags call and return instructions: a call pushes its fall-through address, and a return pops the stack and predicts that address.

The predictor comes out of reset disabled. While `pred_en` is low, every lookup predicts fall-through and no state changes. Software turns prediction on by setting that bit.

Top module: `branch_predictor`

## Requirements
- R1: After reset the target cache holds no valid entries, every direction counter holds weakly not taken, the history register is zero and the return stack is empty. An enabled lookup of any PC that has not since been trained therefore predicts fall-through.
- R2: While `pred_en` is 0, `pred_taken` is 0 and `pred_target` is `fetch_pc + 4`. Updates, calls and returns presented in that state change no predictor state.
- R3: Direction counters use the encoding 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. An enabled update moves the counter one step toward its outcome and saturates at 00 and 11. A lookup that is neither a return nor a cache miss predicts taken, with the cached target, only when its counter is 10 or 11.
- R4: The direction counter index is `pc[13:2]` XOR the 12-bit history register, for both lookup and update.
- R5: Each enabled update shifts its outcome into bit 0 of the history register, and the older bits move up by one.
- R6: The target cache has 2 ways by 256 sets, with set = `pc[9:2]` and tag = `pc[31:10]`. A taken update whose PC already hits overwrites the target in that way.
- R7: A taken update that misses fills way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's LRU bit. The way written becomes most recently used, so the LRU bit names the other way.
- R8: A not-taken update leaves the target cache unchanged.
- R9: An enabled, valid fetch flagged as a call pushes `fetch_pc + 4`. A fetch flagged as a return, when the stack is not empty, predicts taken to the top entry and pops it.
- R10: A return fetched with an empty stack predicts fall-through and leaves the stack empty.
- R11: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry, so only the 8 most recent return addresses can be popped.
- R12: A fetch flagged as both call and return acts as a return only and pushes nothing.
- R13: A lookup sees the predictor state from before any update presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_en | input | 1 | Control bit that enables prediction and training |
| fetch_valid | input | 1 | Fetch presents an instruction this cycle |
| fetch_pc | input | 32 | Program counter being fetched |
| fetch_is_call | input | 1 | Fetched instruction is a call with link |
| fetch_is_ret | input | 1 | Fetched instruction is a subroutine return |
| pred_taken | output | 1 | Predicted redirect |
| pred_target | output | 32 | Predicted next PC |
| upd_valid | input | 1 | Execute reports a resolved branch |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target address |

## Verification
Three branches that share a set are trained in turn, and the first is then looked up. A victim choice that ignored the LRU bit or invalid ways would keep the wrong branch and predict taken where fall-through is expected. Nine calls followed by nine returns show whether a full stack keeps its newest entries and whether the ninth return falls through; a stack that stalled when full, or underflowed into stale data, returns wrong addresses. Training the tables while the predictor is disabled, then enabling it, exposes a design that learns while off. A lookup and a first taken update to the same PC in one cycle catch a write forwarded into the read. A long random mix of updates and fetches over PCs that collide in sets and history indices checks counter saturation and the history-XOR index against an independent model.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int PC_W      = 32;
    localparam int SET_BITS  = 8;
    localparam int GHR_W     = 12;
    localparam int RAS_DEPTH = 8;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef struct packed {
        logic            taken;
        logic [PC_W-1:0] target;
    } pred_t;

    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            default: nxt = taken ? CTR_ST  : CTR_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return (cur == CTR_WT) || (cur == CTR_ST);
    endfunction
endpackage

// File: rtl/bp_dir.sv
module bp_dir
    import bp_pkg::*;
#(
    parameter int P_PC_W  = PC_W,
    parameter int P_GHR_W = GHR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [P_PC_W-1:0]  lk_pc,
    output logic               lk_taken,
    input  logic               up_en,
    input  logic [P_PC_W-1:0]  up_pc,
    input  logic               up_taken,
    output logic [P_GHR_W-1:0] ghr_o
);
    localparam int ENTRIES = 1 << P_GHR_W;

    ctr_e               tbl [ENTRIES];
    logic [P_GHR_W-1:0] ghr;
    logic [P_GHR_W-1:0] lk_idx;
    logic [P_GHR_W-1:0] up_idx;

    // history-folded index for both ports
    assign lk_idx = lk_pc[P_GHR_W+1:2] ^ ghr;
    assign up_idx = up_pc[P_GHR_W+1:2] ^ ghr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WNT;
            ghr <= '0;
        end else if (up_en) begin
            tbl[up_idx] <= ctr_step(tbl[up_idx], up_taken);
            ghr         <= {ghr[P_GHR_W-2:0], up_taken};
        end
    end

    assign lk_taken = ctr_says_taken(tbl[lk_idx]);
    assign ghr_o    = ghr;
endmodule

// File: rtl/bp_btac.sv
module bp_btac
    import bp_pkg::*;
#(
    parameter int P_PC_W     = PC_W,
    parameter int P_SET_BITS = SET_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [P_PC_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic [P_PC_W-1:0] lk_target,
    input  logic              up_en,
    input  logic [P_PC_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [P_PC_W-1:0] up_target
);
    localparam int SETS  = 1 << P_SET_BITS;
    localparam int TAG_W = P_PC_W - P_SET_BITS - 2;
    localparam int WAYS  = 2;   // one LRU bit per set covers exactly two ways

    logic [P_SET_BITS-1:0] lk_set, up_set;
    logic [TAG_W-1:0]      lk_tag, up_tag;
    logic [WAYS-1:0]       lk_way_hit, up_way_hit, up_way_vld, wr_way;
    logic [WAYS-1:0][P_PC_W-1:0] lk_way_dat;
    logic                  lru [SETS];
    logic                  sel;
    logic                  wr_en;

    assign lk_set = lk_pc[P_SET_BITS+1:2];
    assign up_set = up_pc[P_SET_BITS+1:2];
    assign lk_tag = lk_pc[P_PC_W-1:P_SET_BITS+2];
    assign up_tag = up_pc[P_PC_W-1:P_SET_BITS+2];
    assign wr_en  = up_en & up_taken;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic              vld [SETS];
        logic [TAG_W-1:0]  tag [SETS];
        logic [P_PC_W-1:0] dat [SETS];

        assign lk_way_hit[w] = vld[lk_set] && (tag[lk_set] == lk_tag);
        assign lk_way_dat[w] = dat[lk_set];
        assign up_way_hit[w] = vld[up_set] && (tag[up_set] == up_tag);
        assign up_way_vld[w] = vld[up_set];
        assign wr_way[w]     = wr_en && (sel == 1'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SETS; i++) vld[i] <= 1'b0;
            end else if (wr_way[w]) begin
                vld[up_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_way[w]) begin
                tag[up_set] <= up_tag;
                dat[up_set] <= up_target;
            end
        end
    end

    // victim order: existing hit, empty way 0, empty way 1, LRU way
    always_comb begin
        if (up_way_hit[0])       sel = 1'b0;
        else if (up_way_hit[1])  sel = 1'b1;
        else if (!up_way_vld[0]) sel = 1'b0;
        else if (!up_way_vld[1]) sel = 1'b1;
        else                     sel = lru[up_set];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SETS; i++) lru[i] <= 1'b0;
        end else if (wr_en) begin
            lru[up_set] <= ~sel;
        end
    end

    assign lk_hit    = |lk_way_hit;
    assign lk_target = lk_way_hit[1] ? lk_way_dat[1] : lk_way_dat[0];
endmodule

// File: rtl/bp_ras.sv
module bp_ras
    import bp_pkg::*;
#(
    parameter int P_PC_W  = PC_W,
    parameter int P_DEPTH = RAS_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [P_PC_W-1:0]            push_addr,
    input  logic                         pop,
    output logic                         top_valid,
    output logic [P_PC_W-1:0]            top_addr,
    output logic [$clog2(P_DEPTH+1)-1:0] count
);
    localparam int PTR_W = $clog2(P_DEPTH);
    localparam int CNT_W = $clog2(P_DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(P_DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(P_DEPTH);

    logic [P_PC_W-1:0] slot [P_DEPTH];
    logic [PTR_W-1:0]  top;
    logic [PTR_W-1:0]  top_up, top_dn;
    logic [CNT_W-1:0]  cnt;

    assign top_up = (top == PTR_LAST) ? '0 : top + 1'b1;
    assign top_dn = (top == '0) ? PTR_LAST : top - 1'b1;

    // circular storage: wrapping past the oldest slot overwrites it
    always_ff @(posedge clk) begin
        if (rst) begin
            top <= '0;
            cnt <= '0;
        end else if (pop) begin
            if (cnt != '0) begin
                top <= top_dn;
                cnt <= cnt - 1'b1;
            end
        end else if (push) begin
            top <= top_up;
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !pop && push) slot[top_up] <= push_addr;
    end

    assign top_valid = (cnt != '0);
    assign top_addr  = slot[top];
    assign count     = cnt;
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor
    import bp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pred_en,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_is_call,
    input  logic            fetch_is_ret,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int CNT_W = $clog2(RAS_DEPTH + 1);

    logic             dir_taken;
    logic [GHR_W-1:0] ghr_w;
    logic             btac_hit;
    logic [PC_W-1:0]  btac_tgt;
    logic             ras_valid;
    logic [PC_W-1:0]  ras_top;
    logic [CNT_W-1:0] ras_cnt_w;
    logic [PC_W-1:0]  seq_pc;
    logic             upd_en, do_push, do_pop;
    pred_t            pred;

    assign seq_pc  = fetch_pc + PC_W'(4);
    assign upd_en  = pred_en & upd_valid;
    assign do_pop  = pred_en & fetch_valid & fetch_is_ret;
    assign do_push = pred_en & fetch_valid & fetch_is_call & ~fetch_is_ret;

    bp_dir #(.P_PC_W(PC_W), .P_GHR_W(GHR_W)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .lk_pc    (fetch_pc),
        .lk_taken (dir_taken),
        .up_en    (upd_en),
        .up_pc    (upd_pc),
        .up_taken (upd_taken),
        .ghr_o    (ghr_w)
    );

    bp_btac #(.P_PC_W(PC_W), .P_SET_BITS(SET_BITS)) u_btac (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .lk_hit    (btac_hit),
        .lk_target (btac_tgt),
        .up_en     (upd_en),
        .up_pc     (upd_pc),
        .up_taken  (upd_taken),
        .up_target (upd_target)
    );

    bp_ras #(.P_PC_W(PC_W), .P_DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .push_addr (seq_pc),
        .pop       (do_pop),
        .top_valid (ras_valid),
        .top_addr  (ras_top),
        .count     (ras_cnt_w)
    );

    always_comb begin
        pred.taken  = 1'b0;
        pred.target = seq_pc;
        if (pred_en) begin
            if (fetch_is_ret) begin
                if (ras_valid) begin
                    pred.taken  = 1'b1;
                    pred.target = ras_top;
                end
            end else if (btac_hit && dir_taken) begin
                pred.taken  = 1'b1;
                pred.target = btac_tgt;
            end
        end
    end

    assign pred_taken  = pred.taken;
    assign pred_target = pred.target;
endmodule

// File: rtl/bp_checker.sv
module bp_checker
    import bp_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            pred_en,
    input logic                            fetch_valid,
    input logic [PC_W-1:0]                 fetch_pc,
    input logic                            fetch_is_call,
    input logic                            fetch_is_ret,
    input logic                            pred_taken,
    input logic [PC_W-1:0]                 pred_target,
    input logic                            upd_valid,
    input logic                            upd_taken,
    input logic [GHR_W-1:0]                ghr,
    input logic [$clog2(RAS_DEPTH+1)-1:0]  ras_cnt
);
    AST_OFF_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
        !pred_en |-> (!pred_taken && pred_target == fetch_pc + PC_W'(4))); // R2

    AST_GHR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(pred_en && upd_valid) |=> $stable(ghr)); // R2

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (pred_en && upd_valid) |=> ghr == {$past(ghr[GHR_W-2:0]), $past(upd_taken)}); // R5

    AST_RAS_BOUND: assert property (@(posedge clk) disable iff (rst)
        ras_cnt <= RAS_DEPTH); // R11

    AST_RET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (pred_en && fetch_is_ret && ras_cnt == '0) |-> !pred_taken); // R10

    AST_PUSH_GROW: assert property (@(posedge clk) disable iff (rst)
        (pred_en && fetch_valid && fetch_is_call && !fetch_is_ret && ras_cnt < RAS_DEPTH)
        |=> ras_cnt == $past(ras_cnt) + 1'b1); // R9

    AST_DUAL_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        (pred_en && fetch_valid && fetch_is_call && fetch_is_ret)
        |=> ras_cnt <= $past(ras_cnt)); // R12
endmodule

bind branch_predictor bp_checker u_bp_checker (
    .clk           (clk),
    .rst           (rst),
    .pred_en       (pred_en),
    .fetch_valid   (fetch_valid),
    .fetch_pc      (fetch_pc),
    .fetch_is_call (fetch_is_call),
    .fetch_is_ret  (fetch_is_ret),
    .pred_taken    (pred_taken),
    .pred_target   (pred_target),
    .upd_valid     (upd_valid),
    .upd_taken     (upd_taken),
    .ghr           (ghr_w),
    .ras_cnt       (ras_cnt_w)
);

// File: tb/branch_predictor_bench.sv
module branch_predictor_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pred_en = 1'b0, fetch_valid = 1'b0, fetch_is_call = 1'b0, fetch_is_ret = 1'b0;
    logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
    logic        upd_valid = 1'b0, upd_taken = 1'b0;
    logic        pred_taken;
    logic [31:0] pred_target;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    int          m_ctr [4096];
    logic [11:0] m_ghr;
    bit          m_vld [2][256];
    logic [21:0] m_tag [2][256];
    logic [31:0] m_dat [2][256];
    bit          m_lru [256];
    logic [31:0] m_ras [8];
    int          m_top, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_predictor u_branch_predictor (
        .clk(clk), .rst(rst), .pred_en(pred_en), .fetch_valid(fetch_valid),
        .fetch_pc(fetch_pc), .fetch_is_call(fetch_is_call), .fetch_is_ret(fetch_is_ret),
        .pred_taken(pred_taken), .pred_target(pred_target), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) m_ctr[i] = 1;
        for (int s = 0; s < 256; s++) begin
            m_vld[0][s] = 0; m_vld[1][s] = 0; m_lru[s] = 0;
        end
        m_ghr = '0; m_top = 0; m_cnt = 0;
    endtask

    function automatic int way_hit(input logic [31:0] pc);
        int s;
        s = int'(pc[9:2]);
        for (int w = 0; w < 2; w++)
            if (m_vld[w][s] && m_tag[w][s] == pc[31:10]) return w;
        return -1;
    endfunction

    // expected prediction from the requirements (R2, R3, R9, R10)
    function automatic logic [32:0] expect_pred(input bit en, input logic [31:0] pc, input bit ret);
        int w;
        if (!en) return {1'b0, pc + 32'd4};
        if (ret) return (m_cnt > 0) ? {1'b1, m_ras[m_top]} : {1'b0, pc + 32'd4};
        w = way_hit(pc);
        if (w >= 0 && m_ctr[int'(pc[13:2] ^ m_ghr)] >= 2) return {1'b1, m_dat[w][int'(pc[9:2])]};
        return {1'b0, pc + 32'd4};
    endfunction

    task automatic model_apply(input bit en, input bit fv, input logic [31:0] pc, input bit call, input bit ret,
                               input bit uv, input logic [31:0] upc, input bit ut, input logic [31:0] utgt);
        int idx, s, w;
        if (en && fv) begin
            if (ret) begin
                if (m_cnt > 0) begin m_top = (m_top + 7) % 8; m_cnt--; end
            end else if (call) begin
                m_top = (m_top + 1) % 8; m_ras[m_top] = pc + 32'd4;
                if (m_cnt < 8) m_cnt++;
            end
        end
        if (en && uv) begin
            idx = int'(upc[13:2] ^ m_ghr);
            if (ut) m_ctr[idx] = (m_ctr[idx] < 3) ? m_ctr[idx] + 1 : 3;
            else    m_ctr[idx] = (m_ctr[idx] > 0) ? m_ctr[idx] - 1 : 0;
            m_ghr = {m_ghr[10:0], ut};
            if (ut) begin
                s = int'(upc[9:2]);
                w = way_hit(upc);
                if (w < 0) w = !m_vld[0][s] ? 0 : (!m_vld[1][s] ? 1 : int'(m_lru[s]));
                m_vld[w][s] = 1; m_tag[w][s] = upc[31:10]; m_dat[w][s] = utgt;
                m_lru[s] = (w == 0);
            end
        end
    endtask

    task automatic step(input string req, input bit en, input bit fv, input logic [31:0] pc, input bit call,
                        input bit ret, input bit uv, input logic [31:0] upc, input bit ut, input logic [31:0] utgt);
        logic [32:0] e;
        @(negedge clk);
        pred_en = en; fetch_valid = fv; fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        #1;
        e = expect_pred(en, pc, ret);
        if (fv) begin
            chk(req, "pred_taken", {31'd0, pred_taken}, {31'd0, e[32]});
            chk(req, "pred_target", pred_target, e[31:0]);
        end
        model_apply(en, fv, pc, call, ret, uv, upc, ut, utgt);
    endtask

    task automatic fetch(input string req, input logic [31:0] pc, input bit call, input bit ret);
        step(req, 1, 1, pc, call, ret, 0, 0, 0, 0);
    endtask

    task automatic train(input string req, input logic [31:0] upc, input bit ut, input logic [31:0] utgt);
        step(req, 1, 0, 0, 0, 0, 1, upc, ut, utgt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset leaves prediction off and fall-through
        chk("R1", "pred_taken after reset", {31'd0, pred_taken}, 32'd0);
        fetch("R1", 32'h0000_1000, 0, 0);

        // R2: training, calls and returns while disabled must leave no trace
        for (int i = 0; i < 6; i++) step("R2", 0, 1, 32'h0000_2000, 1, 0, 1, 32'h0000_2000, 1, 32'h0000_3000);
        fetch("R2", 32'h0000_2000, 0, 0);
        fetch("R2", 32'h0000_2400, 0, 1);

        // R13: first taken update and lookup of the same PC in one cycle
        step("R13", 1, 1, 32'h0000_5010, 0, 0, 1, 32'h0000_5010, 1, 32'h0000_6000);

        // R3, R5: saturate one counter with a stable all-ones history
        for (int i = 0; i < 14; i++) train("R3", 32'h0000_0840, 1, 32'h0000_0900);
        fetch("R3", 32'h0000_0840, 0, 0);
        train("R3", 32'h0000_0840, 0, 0);
        fetch("R4", 32'h0000_0840, 0, 0);
        train("R8", 32'h0000_0840, 0, 0);
        fetch("R8", 32'h0000_0840, 0, 0);

        // R6, R7: three taken branches in set 4, first one evicted
        train("R7", 32'h0000_1010, 1, 32'h0000_A000);
        train("R7", 32'h0000_2010, 1, 32'h0000_B000);
        train("R6", 32'h0000_2010, 1, 32'h0000_B100);
        train("R7", 32'h0000_4010, 1, 32'h0000_C000);
        for (int i = 0; i < 13; i++) train("R7", 32'h0000_2010, 1, 32'h0000_B100);
        fetch("R7", 32'h0000_1010, 0, 0);
        fetch("R6", 32'h0000_2010, 0, 0);

        // R9, R10, R11: overflow then drain the return stack
        for (int i = 0; i < 9; i++) fetch("R11", 32'h0001_0000 + 32'(i * 64), 1, 0);
        for (int i = 0; i < 9; i++) fetch("R11", 32'h0002_0000, 0, 1);
        fetch("R10", 32'h0002_0100, 0, 1);

        // R12: call and return in one fetch
        fetch("R9", 32'h0003_0000, 1, 0);
        fetch("R12", 32'h0003_0100, 1, 1);
        fetch("R12", 32'h0003_0200, 0, 1);

        // random mix over colliding PCs
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] pc, upc, tgt;
            bit call, ret, uv, ut, fv;
            pc   = (32'($urandom_range(1, 3)) << 10) | (32'($urandom_range(0, 3)) << 2);
            upc  = (32'($urandom_range(1, 3)) << 10) | (32'($urandom_range(0, 3)) << 2);
            tgt  = {$urandom_range(0, 65535), 2'b00};
            ret  = ($urandom_range(0, 9) == 0);
            call = ($urandom_range(0, 9) == 0);
            uv   = ($urandom_range(0, 1) == 1);
            ut   = ($urandom_range(0, 3) != 0);
            fv   = ($urandom_range(0, 7) != 0);
            step(ret ? "R9" : "R3", ($urandom_range(0, 15) != 0), fv, pc, call, ret, uv, upc, ut, tgt);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule